// File: doc/BRIEF.md
# Serial-Peripheral-Interface Byte Memory Slave

This block lets an SPI master reach a 512-byte on-chip store. The master lowers chip select, shifts in a one-byte command and, for memory commands, one address byte, then streams data bytes in or out. The byte address is 9 bits wide. The top bit travels inside the command byte, and the following byte carries the lower eight bits. Writes land in the store as each byte completes, so the master never waits or polls for a ready state.

The block runs on a fast system clock. Each cycle it samples SCK, SI, active-low chip select and active-low hold, and finds SCK edges by comparing with the previous sample. SPI modes 0 and 3 are handled the same way, because the first rising SCK edge after chip select falls always carries the first command bit. SO comes out as a data bit plus an output-enable, so the chip pad can float the pin.

The controller has six states. IDLE waits for chip select to fall. OPCODE takes the command byte. From OPCODE, a read or write command goes to ADDR and any other command goes to DONE. ADDR takes the low address byte and then moves to WDATA for a write or RDATA for a read. WDATA takes data bytes, RDATA sends data bytes, and DONE ignores all SCK activity. A rising chip select returns every state to IDLE.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, so_oe is low, the write-enable latch is clear, and every byte of the store reads back as 0x00.
- R2: SI is sampled on each rising SCK edge. Bits arrive most significant first, and the first rising edge after cs_n falls carries bit 7 of the command. This holds whether SCK idles low (mode 0) or high (mode 3).
- R3: The command byte 0x06 sets the write-enable latch and 0x04 clears it. The read command is 0x03 and the write command is 0x02. In both, bit 3 of the command byte holds address bit 8, and the next byte holds address bits 7..0.
- R4: During a read, each data bit is driven on SO at a falling SCK edge, most significant bit first. The first bit appears at the falling edge that follows the eighth rising edge of the address byte.
- R5: A data byte of a write command reaches the store only if the write-enable latch is set. Otherwise the store is unchanged.
- R6: When cs_n rises at the end of a write command, the write-enable latch is cleared.
- R7: In a burst read or write, the address advances by one after each data byte and wraps from 0x1FF to 0x000.
- R8: Only the first byte of a window is decoded as a command. Bytes after a write-enable, a write-disable or an unrecognised command have no effect until cs_n rises.
- R9: so_oe is low whenever cs_n is high or no read data is being shifted out.
- R10: While hold_n is low and SCK is low, SCK edges are ignored and so_oe is low. When hold_n returns high, the transfer resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all SPI pins |
| rst_n | input | 1 | Active-low power-on reset; clears the store and the latch |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data in from the master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; low means the pin floats |

## Verification
The hardest case to reach is a pause in the middle of a read byte. For this, hold_n must fall while SCK is low, SCK must keep toggling while the pause lasts, and the bit stream must then resume with no bit lost or repeated. The bench reaches it with a directed read that asserts hold_n at a chosen bit position, toggles SCK during the pause, checks that SO floats, and compares the whole byte afterwards. Random traffic then mixes modes 0 and 3, latch states, command types, and burst starts close to 0x1FF, so that write-enable clearing and address wrap both occur many times.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } spi_state_e;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam int         OPC_HI_POS = 3;
endpackage

// File: rtl/spi_mem_edge.sv
module spi_mem_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic held
);
    logic sck_q;
    logic held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            sck_q <= sck;
            if (!sck) held_q <= !hold_n;
        end
    end

    assign held     = held_q;
    assign sck_rise =  sck && !sck_q && !held_q;
    assign sck_fall = !sck &&  sck_q && !held_q;
endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    import spi_mem_pkg::*;

    localparam int AW    = DW + 1;
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);
    localparam logic [DW-1:0]    HI_MASK  = ~(DW'(1) << OPC_HI_POS);

    spi_state_e     st, st_nx;
    logic           sck_rise, sck_fall, held;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-2:0]  shin;
    logic [DW-1:0]  byte_in;
    logic           byte_done;
    logic           cmd_wr, wel, a_hi, rd_live;
    logic [AW-1:0]  addr, mem_raddr;
    logic [DW-1:0]  tx_sh, mem_rdata;
    logic           mem_we, so_bit, so_oe_q;
    logic           op_rd, op_wr;

    spi_mem_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .held     (held)
    );

    spi_mem_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr),
        .wdata (byte_in),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign byte_in   = {shin, si};
    assign byte_done = sck_rise && !cs_n && (bit_cnt == LAST_BIT);
    assign op_rd     = (byte_in & HI_MASK) == DW'(OPC_READ);
    assign op_wr     = (byte_in & HI_MASK) == DW'(OPC_WRITE);
    assign mem_we    = byte_done && (st == ST_WDATA) && wel;
    assign mem_raddr = (st == ST_ADDR) ? {a_hi, byte_in} : AW'(addr + 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state decode
    always_comb begin
        st_nx = st;
        if (cs_n) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_nx = ST_OPCODE;
                ST_OPCODE: if (byte_done) st_nx = (op_rd || op_wr) ? ST_ADDR : ST_DONE;
                ST_ADDR:   if (byte_done) st_nx = cmd_wr ? ST_WDATA : ST_RDATA;
                ST_WDATA:  st_nx = ST_WDATA;
                ST_RDATA:  st_nx = ST_RDATA;
                ST_DONE:   st_nx = ST_DONE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shin    <= '0;
            cmd_wr  <= 1'b0;
            wel     <= 1'b0;
            a_hi    <= 1'b0;
            addr    <= '0;
            tx_sh   <= '0;
            rd_live <= 1'b0;
            so_bit  <= 1'b0;
            so_oe_q <= 1'b0;
        end else begin
            if (cs_n) begin
                bit_cnt <= '0;
                rd_live <= 1'b0;
                cmd_wr  <= 1'b0;
                if (cmd_wr) wel <= 1'b0;
            end else begin
                if (sck_rise) begin
                    shin    <= byte_in[DW-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    unique case (st)
                        ST_OPCODE: begin
                            if (byte_in == DW'(OPC_WREN)) wel <= 1'b1;
                            if (byte_in == DW'(OPC_WRDI)) wel <= 1'b0;
                            cmd_wr <= op_wr;
                            a_hi   <= byte_in[OPC_HI_POS];
                        end
                        ST_ADDR: begin
                            addr  <= {a_hi, byte_in};
                            tx_sh <= mem_rdata;
                        end
                        ST_WDATA: addr <= addr + 1'b1;
                        ST_RDATA: begin
                            addr  <= addr + 1'b1;
                            tx_sh <= mem_rdata;
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && st == ST_RDATA) begin
                    so_bit  <= tx_sh[DW-1];
                    tx_sh   <= {tx_sh[DW-2:0], 1'b0};
                    rd_live <= 1'b1;
                end
            end
            so_oe_q <= !cs_n && rd_live && !held;
        end
    end

    assign so    = so_bit;
    assign so_oe = so_oe_q;

    // R9
    so_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cmd_wr) |=> !wel);

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_n) |=> $stable(bit_cnt));

    // R7
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_WDATA && addr == '1) |=> (addr == '0));

    // R8
    one_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (st != ST_OPCODE && st != ST_ADDR));
endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model_mem [512];
    bit model_wel = 1'b0;
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;

    spi_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si),
        .cs_n(cs_n), .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clkn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input bit m3);
        sck = m3;
        clkn(2);
        cs_n = 1'b0;
        clkn(4);
        if (m3) begin sck = 1'b0; clkn(4); end
    endtask

    task automatic cs_end(input bit m3);
        if (m3) begin sck = 1'b1; clkn(4); end
        cs_n = 1'b1;
        clkn(6);
        check(so_oe == 1'b0, "R9 so_oe after cs_n high", so_oe, 0);
        sck = 1'b0;
        clkn(2);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_at,
                        output logic [7:0] rx, output bit oe_and, output bit oe_or);
        oe_and = 1'b1;
        oe_or  = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            clkn(4);
            if (i == hold_at) begin
                hold_n = 1'b0;
                clkn(4);
                check(so_oe == 1'b0, "R10 SO floats during hold", so_oe, 0);
                sck = 1'b1; clkn(3); sck = 1'b0; clkn(3);
                sck = 1'b1; clkn(3); sck = 1'b0; clkn(3);
                check(so_oe == 1'b0, "R10 SO floats while SCK toggles in hold", so_oe, 0);
                hold_n = 1'b1;
                clkn(4);
            end
            rx[i]  = so;
            oe_and = oe_and & so_oe;
            oe_or  = oe_or | so_oe;
            sck = 1'b1;
            clkn(4);
            sck = 1'b0;
        end
    endtask

    task automatic op_only(input logic [7:0] op, input bit m3);
        logic [7:0] rx; bit a, o;
        cs_begin(m3);
        xfer(op, -1, rx, a, o);
        cs_end(m3);
        if (op == 8'h06) model_wel = 1'b1;
        if (op == 8'h04) model_wel = 1'b0;
    endtask

    task automatic do_write(input logic [8:0] adr, input int n, input bit m3);
        logic [7:0] rx; bit a, o;
        cs_begin(m3);
        xfer(8'h02 | {4'h0, adr[8], 3'b000}, -1, rx, a, o);
        xfer(adr[7:0], -1, rx, a, o);
        for (int k = 0; k < n; k++) begin
            xfer(wbuf[k], -1, rx, a, o);
            if (model_wel) model_mem[9'(adr + 9'(k))] = wbuf[k];
        end
        cs_end(m3);
        model_wel = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] adr, input int n, input bit m3,
                           input int hold_at, input string req);
        logic [7:0] rx; bit a, o;
        cs_begin(m3);
        xfer(8'h03 | {4'h0, adr[8], 3'b000}, -1, rx, a, o);
        xfer(adr[7:0], -1, rx, a, o);
        for (int k = 0; k < n; k++) begin
            logic [7:0] exp;
            exp = model_mem[9'(adr + 9'(k))];
            xfer(8'($urandom), (k == 0) ? hold_at : -1, rx, a, o);
            check(rx == exp, req, {23'd0, 9'(adr + 9'(k))} << 8 | 32'(rx), {23'd0, 9'(adr + 9'(k))} << 8 | 32'(exp));
            check(a, "R4 so_oe high while read bits shift", 32'(a), 1);
        end
        cs_end(m3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] rx; bit a, o;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 512; i++) model_mem[i] = 8'h00;
        clkn(5);
        rst_n = 1'b1;
        clkn(3);
        check(so_oe == 1'b0, "R1 R9 so_oe low after reset", so_oe, 0);
        do_read(9'h000, 4, 1'b0, -1, "R1 R4 store reads zero after reset");
        do_read(9'h1FF, 1, 1'b1, -1, "R1 R2 mode3 top byte zero after reset");

        // R5: write with latch clear is dropped
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        do_write(9'h010, 2, 1'b0);
        do_read(9'h010, 2, 1'b0, -1, "R5 write without latch ignored");

        // R3 R7 normal burst write and read
        op_only(8'h06, 1'b0);
        wbuf[0] = 8'h11; wbuf[1] = 8'h82; wbuf[2] = 8'hF0;
        do_write(9'h010, 3, 1'b0);
        do_read(9'h010, 3, 1'b0, -1, "R3 R7 burst write then read");

        // R6: latch cleared by end of previous write
        wbuf[0] = 8'h77;
        do_write(9'h011, 1, 1'b0);
        do_read(9'h011, 1, 1'b0, -1, "R6 latch cleared after write window");

        // R7 R3 wrap with address bit 8 set
        op_only(8'h06, 1'b1);
        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        do_write(9'h1FE, 4, 1'b1);
        do_read(9'h1FE, 4, 1'b0, -1, "R7 R3 wrap 0x1FF to 0x000");

        // R3: write-disable clears latch
        op_only(8'h06, 1'b0);
        op_only(8'h04, 1'b0);
        wbuf[0] = 8'h99;
        do_write(9'h020, 1, 1'b0);
        do_read(9'h020, 1, 1'b0, -1, "R3 write-disable blocks write");

        // R8: trailing bytes after an op-only command
        cs_begin(1'b0);
        xfer(8'h06, -1, rx, a, o);
        xfer(8'h02, -1, rx, a, o);
        xfer(8'h20, -1, rx, a, o);
        xfer(8'h55, -1, rx, a, o);
        cs_end(1'b0);
        model_wel = 1'b1;
        do_read(9'h020, 1, 1'b0, -1, "R8 bytes after opcode ignored");
        // R8 R9: unknown command then read-like bytes give no output
        cs_begin(1'b1);
        xfer(8'hFF, -1, rx, a, o);
        xfer(8'h03, -1, rx, a, o);
        xfer(8'h00, -1, rx, a, o);
        xfer(8'h00, -1, rx, a, o);
        check(!o, "R8 R9 no SO after unknown command", 32'(o), 0);
        cs_end(1'b1);
        // latch still set from WREN window: a write succeeds (R5)
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        do_write(9'h0F0, 2, 1'b0);
        // R10 hold in mid byte, R2 mode 3
        do_read(9'h0F0, 2, 1'b1, 4, "R10 R2 read resumes after hold");
        do_read(9'h0F1, 1, 1'b0, 0, "R10 hold at last bit");

        // random mix
        for (int t = 0; t < 70; t++) begin
            int kind;
            bit m3;
            logic [8:0] adr;
            int n;
            kind = int'($urandom % 5);
            m3   = 1'($urandom);
            adr  = ($urandom % 4 == 0) ? 9'(9'h1FC + 9'($urandom % 4)) : 9'($urandom);
            n    = 1 + int'($urandom % 5);
            case (kind)
                0: op_only(8'h06, m3);
                1: op_only(8'h04, m3);
                2, 3: begin
                    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                    if ($urandom % 3 != 0) op_only(8'h06, m3);
                    do_write(adr, n, m3);
                end
                default: do_read(adr, n, m3, ($urandom % 4 == 0) ? int'($urandom % 8) : -1,
                                 "R2 R4 R5 R7 random read");
            endcase
        end
        do_read(9'h1FC, 6, 1'b0, -1, "R7 final wrap sweep");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule